// File: doc/BRIEF.md
# Raster-Op Display Pixel Write Unit

This unit sits between a CPU byte port and a bit-addressable monochrome display memory of 240 rows by 168 columns, where a stored 1 lights a pixel and a stored 0 leaves it dark. Each request names a base pixel, a byte orientation, a logical operation, a data byte and a protection mask. A write request reads the eight pixels the byte covers and combines them with the CPU byte. It keeps the stored value of every protected pixel and stores the result back. A read request returns those eight pixels with the protected ones forced to zero and leaves the memory untouched.

The byte covers either eight pixels going down a column (vertical) or eight pixels going right along a row (horizontal). In both cases byte bit 7 is the base pixel. Every access runs a fixed three-cycle sequence: fetch, combine, store. The memory is held inside the unit as a synchronous array with one-cycle read latency.

Top module: `rop_pixel_unit`

## Requirements
- R1: `req_op` selects the write operation on new data D and stored data S: 3'b000 result D, 3'b001 S AND D, 3'b010 S OR D, 3'b011 S XOR D, 3'b100 NOT S; codes 3'b101 to 3'b111 leave S unchanged.
- R2: On a write, every pixel whose `req_mask` bit is 1 keeps its stored value, whatever the operation.
- R3: A read (`req_write`=0) raises `rd_valid` for one cycle with `rd_data` equal to the stored byte with masked bits forced to 0, and changes no pixel.
- R4: With `req_vert`=1, byte bit 7-i maps to pixel (row+i, col) for i in 0..7, so bit 7 is the top pixel.
- R5: With `req_vert`=0, byte bit 7-i maps to pixel (row, col+i) for i in 0..7, so bit 7 is the left pixel.
- R6: Pixels of a byte that fall at row 240 or above or column 168 or above are not written and read back as 0.
- R7: A request is accepted on a clock edge where `req_valid`=1 and `busy`=0. `busy` is then high for exactly three cycles. For a read, `rd_valid` is high in the third of them, and a write's store takes effect at the edge that ends them.
- R8: Requests presented while `busy` is high are ignored: they change no pixel and produce no read strobe.
- R9: After reset `busy` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_vert | input | 1 | 1 vertical byte, 0 horizontal byte |
| req_op | input | 3 | Operation code |
| req_row | input | 8 | Base pixel row |
| req_col | input | 8 | Base pixel column |
| req_data | input | 8 | CPU data byte |
| req_mask | input | 8 | Per-bit protect mask, 1 protects |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 8 | Masked read byte |

## Verification
A new request can arrive in the same cycle that a previous access is fetching, combining or storing. The bench provokes this by keeping `req_valid` high with random write requests through all three busy cycles of every access. Every later read is then compared against a bench model that applied only the accepted requests, so a request that slipped through shows up as a pixel mismatch. The bench also checks that `busy` and `rd_valid` follow the exact cycle pattern during that overlap.

// File: rtl/rop_pixel_unit.sv
module rop_pixel_unit #(
  parameter int ROWS = 240,
  parameter int COLS = 168,
  parameter int RW   = 8,
  parameter int CW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_vert,
  input  logic [2:0]    req_op,
  input  logic [RW-1:0] req_row,
  input  logic [CW-1:0] req_col,
  input  logic [7:0]    req_data,
  input  logic [7:0]    req_mask,
  output logic          busy,
  output logic          rd_valid,
  output logic [7:0]    rd_data
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_COMB, S_STORE} st_t;
  localparam logic [RW:0] ROW_LIM = (RW+1)'(ROWS);
  localparam logic [CW:0] COL_LIM = (CW+1)'(COLS);

  st_t st;
  logic          lw, lv;
  logic [2:0]    lop;
  logic [RW-1:0] lrow;
  logic [CW-1:0] lcol;
  logic [7:0]    ld, lm, cur, res, opv, gath, inr;
  logic [RW:0]   ra [8];
  logic [CW:0]   ca [8];
  logic [COLS-1:0] mem [ROWS];

  assign busy     = (st != S_IDLE);
  assign rd_valid = (st == S_STORE) && !lw;
  assign rd_data  = res;

  for (genvar g = 0; g < 8; g++) begin : g_pix
    assign ra[g]  = {1'b0, lrow} + (lv ? (RW+1)'(g) : '0);
    assign ca[g]  = {1'b0, lcol} + (lv ? '0 : (CW+1)'(g));
    assign inr[g] = (ra[g] < ROW_LIM) && (ca[g] < COL_LIM);
    assign gath[7-g] = inr[g] && mem[ra[g][RW-1:0]][ca[g][CW-1:0]];
  end

  always_comb begin
    case (lop)
      3'b000:  opv = ld;
      3'b001:  opv = cur & ld;
      3'b010:  opv = cur | ld;
      3'b011:  opv = cur ^ ld;
      3'b100:  opv = ~cur;
      default: opv = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      lw <= 1'b0; lv <= 1'b0; lop <= '0;
      lrow <= '0; lcol <= '0; ld <= '0; lm <= '0;
      cur <= '0; res <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          lw <= req_write; lv <= req_vert; lop <= req_op;
          lrow <= req_row; lcol <= req_col; ld <= req_data; lm <= req_mask;
          st <= S_FETCH;
        end
        S_FETCH: begin
          cur <= gath;
          st  <= S_COMB;
        end
        S_COMB: begin
          res <= lw ? ((opv & ~lm) | (cur & lm)) : (cur & ~lm);
          st  <= S_STORE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_STORE && lw)
      for (int i = 0; i < 8; i++)
        if (inr[i]) mem[ra[i][RW-1:0]][ca[i][CW-1:0]] <= res[7-i];
  end

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy ##1 !busy);
  // R8
  refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(lrow) && $stable(lcol) && $stable(ld) && $stable(lop) && $stable(lw)));
  // R3
  rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((rd_data & lm) == 8'h00));
  // R3
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

// File: tb/rop_pixel_unit_test.sv
`timescale 1ns/1ps
module rop_pixel_unit_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_vert = 0;
  logic [2:0] req_op = 0;
  logic [7:0] req_row = 0, req_col = 0, req_data = 0, req_mask = 0;
  logic busy, rd_valid;
  logic [7:0] rd_data;
  int checks = 0, failures = 0;
  logic [167:0] mdl [240];

  always #2.5 clk = ~clk;

  rop_pixel_unit uut (.clk, .rst_n, .req_valid, .req_write, .req_vert, .req_op,
    .req_row, .req_col, .req_data, .req_mask, .busy, .rd_valid, .rd_data);

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_get(int row, int col, bit v);
    logic [7:0] b = 0;
    for (int i = 0; i < 8; i++) begin
      int r = row + (v ? i : 0);
      int c = col + (v ? 0 : i);
      if (r < 240 && c < 168) b[7-i] = mdl[r][c];
    end
    return b;
  endfunction

  function automatic logic [7:0] op_ref(logic [2:0] op, logic [7:0] s, logic [7:0] d);
    if (op == 3'b000) return d;
    if (op == 3'b001) return s & d;
    if (op == 3'b010) return s | d;
    if (op == 3'b011) return s ^ d;
    if (op == 3'b100) return ~s;
    return s;
  endfunction

  task automatic m_put(int row, int col, bit v, logic [2:0] op, logic [7:0] d, logic [7:0] m);
    logic [7:0] s = m_get(row, col, v);
    logic [7:0] n = (op_ref(op, s, d) & ~m) | (s & m);
    for (int i = 0; i < 8; i++) begin
      int r = row + (v ? i : 0);
      int c = col + (v ? 0 : i);
      if (r < 240 && c < 168) mdl[r][c] = n[7-i];
    end
  endtask

  task automatic access(input bit w, input bit v, input logic [2:0] op, input int row,
                        input int col, input logic [7:0] d, input logic [7:0] m,
                        output logic [7:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = w; req_vert = v; req_op = op;
    req_row = 8'(row); req_col = 8'(col); req_data = d; req_mask = m;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(busy == 1, "R7 busy during access", {7'b0, busy}, 8'h01);
      req_write = 1; req_op = 3'($urandom % 5); req_vert = 1'($urandom);
      req_row = 8'($urandom % 240); req_col = 8'($urandom % 168);
      req_data = 8'($urandom); req_mask = 8'($urandom);
      if (k == 2) begin
        chk(rd_valid == !w, "R7 rd_valid in third busy cycle", {7'b0, rd_valid}, {7'b0, !w});
        rd = rd_data;
      end else
        chk(rd_valid == 0, "R8 no strobe early", {7'b0, rd_valid}, 8'h00);
    end
    @(negedge clk);
    req_valid = 0;
    chk(busy == 0 && rd_valid == 0, "R7 R8 idle after access", {6'b0, busy, rd_valid}, 8'h00);
    if (w) m_put(row, col, v, op, d, m);
  endtask

  task automatic rd_chk(int row, int col, bit v, logic [7:0] m, string tag);
    logic [7:0] got, exp;
    access(0, v, 3'b000, row, col, 8'h00, m, got);
    exp = m_get(row, col, v) & ~m;
    chk(got == exp, tag, got, exp);
  endtask

  task automatic wr(int row, int col, bit v, logic [2:0] op, logic [7:0] d, logic [7:0] m);
    logic [7:0] junk;
    access(1, v, op, row, col, d, m, junk);
  endtask

  initial begin
    logic [7:0] got;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 0 && rd_valid == 0, "R9 reset outputs", {6'b0, busy, rd_valid}, 8'h00);
    rst_n = 1;
    for (int r = 0; r < 240; r++) mdl[r] = '0;
    for (int r = 0; r < 240; r++)
      for (int c = 0; c < 168; c += 8) wr(r, c, 0, 3'b000, 8'h00, 8'h00);

    rd_chk(10, 16, 0, 8'h00, "R3 cleared read");
    wr(10, 16, 0, 3'b000, 8'hA5, 8'h00);
    access(0, 0, 3'b000, 10, 16, 8'h00, 8'h00, got);
    chk(got == 8'hA5, "R5 horizontal set", got, 8'hA5);
    access(0, 1, 3'b000, 10, 16, 8'h00, 8'h00, got);
    chk(got == 8'h80, "R4 vertical view of row byte", got, 8'h80);
    wr(20, 30, 1, 3'b000, 8'h3C, 8'h00);
    access(0, 0, 3'b000, 22, 30, 8'h00, 8'h00, got);
    chk(got == 8'h80, "R4 vertical bit order", got, 8'h80);
    for (int op = 0; op < 8; op++) begin
      wr(40, 40, op[0], 3'(op), 8'h5A, 8'h00);
      rd_chk(40, 40, op[0], 8'h00, "R1 operation result");
    end
    wr(50, 48, 0, 3'b000, 8'hFF, 8'hF0);
    access(0, 0, 3'b000, 50, 48, 8'h00, 8'h00, got);
    chk(got == 8'h0F, "R2 masked write", got, 8'h0F);
    access(0, 0, 3'b000, 50, 48, 8'h00, 8'h0F, got);
    chk(got == 8'h00, "R3 masked read zero", got, 8'h00);
    wr(60, 165, 0, 3'b000, 8'hFF, 8'h00);
    access(0, 0, 3'b000, 60, 165, 8'h00, 8'h00, got);
    chk(got == 8'hE0, "R6 right edge clip", got, 8'hE0);
    access(0, 0, 3'b000, 61, 0, 8'h00, 8'h00, got);
    chk(got == 8'h00, "R6 no wrap to next row", got, 8'h00);
    wr(236, 100, 1, 3'b000, 8'hFF, 8'h00);
    access(0, 1, 3'b000, 236, 100, 8'h00, 8'h00, got);
    chk(got == 8'hF0, "R6 bottom edge clip", got, 8'hF0);
    access(0, 1, 3'b000, 0, 100, 8'h00, 8'h00, got);
    chk(got == 8'h00, "R6 no wrap to top", got, 8'h00);
    wr(70, 200, 0, 3'b000, 8'hFF, 8'h00);
    access(0, 0, 3'b000, 70, 200, 8'h00, 8'h00, got);
    chk(got == 8'h00, "R6 base column out of range", got, 8'h00);

    for (int n = 0; n < 700; n++) begin
      bit v = 1'($urandom);
      int row = ($urandom % 2) ? 230 + $urandom % 10 : $urandom % 240;
      int col = ($urandom % 2) ? 158 + $urandom % 10 : $urandom % 168;
      if ($urandom % 3 == 0)
        rd_chk(row, col, v, 8'($urandom), "R3 R8 random read");
      else begin
        wr(row, col, v, 3'($urandom), 8'($urandom), 8'($urandom));
        rd_chk(row, col, 1'($urandom), 8'h00, "R1 R2 R4 R5 R6 random write");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule